// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A sixteen-state sequencer advances on every rising edge of the test clock, steered only by the mode-select input. One branch of the sequence captures, shifts and updates a 4-bit instruction register. A parallel branch does the same for whichever data register the most recently loaded instruction selects. Three data paths are available: a one-bit bypass stage, a 32-bit identification register holding a fixed device identity, and an external boundary chain whose cells live outside this block.

For the boundary chain the block provides capture, shift and update strobes and a test-mode flag that hands the pins to the chain. It receives the chain's serial output back on `bnd_so`. The chain's serial input is the same `tdi` pin. The serial output changes on the falling clock edge. It is marked valid only while a shift state is active. Board software drives the port with the usual sequences: park in idle, walk into an instruction or data scan, shift, and update.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising `tck` edge, the sequencer enters its reset state and the instruction becomes the identification code 4'b0010. `tdo` and `tdo_oe` are cleared at the next falling edge.
- R2: `tms` is sampled on rising `tck`, and every one of the 16 states has exactly two successors chosen by that bit. The states are reset, idle, and for each of the data and instruction branches: select, capture, shift, exit-1, pause, exit-2, update. The transitions follow the standard test-port graph, so pause and exit-2 return to shift.
- R3: After five consecutive rising edges with `tms` high, the sequencer is in its reset state from any starting state. One more rising edge in that state loads the identification code into the instruction.
- R4: Capture-IR loads 4'b0101, so the two low captured bits are 2'b01. Shift-IR shifts least significant bit first. Update-IR makes the shifted code appear on `instr` after that edge.
- R5: Instruction 4'b0000 (external test) and 4'b0001 (sample/preload) route the data scan through the boundary chain: `tdo` follows `bnd_so`. 4'b0010 selects the identification register. 4'b1111 and every other unlisted code select the bypass stage.
- R6: The bypass stage captures 0 in Capture-DR and delays `tdi` by exactly one shift.
- R7: The identification register captures the 32-bit `ID_VALUE`, whose bit 0 is 1, and shifts it out least significant bit first.
- R8: `tdo` and `tdo_oe` update on falling `tck`. `tdo_oe` is 1 only while the state is Shift-IR or Shift-DR. Otherwise `tdo` is 0 and `tdo_oe` is 0.
- R9: `bnd_capture`, `bnd_shift` and `bnd_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while a boundary instruction is loaded. At most one of them is high at a time.
- R10: `ext_mode` is high exactly while the loaded instruction is 4'b0000. It can only become high at the edge leaving Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, also feeds the external boundary chain |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| bnd_capture | output | 1 | Boundary chain capture strobe |
| bnd_shift | output | 1 | Boundary chain shift enable |
| bnd_update | output | 1 | Boundary chain update strobe |
| ext_mode | output | 1 | Pins under boundary-chain control |
| instr | output | 4 | Currently loaded instruction |

## Verification
Two situations are hard to reach from the pins. The first is a return to reset from deep inside a scan, such as mid Shift-DR or mid Shift-IR. The bench walks into those states with explicit TMS sequences and then holds TMS high for five edges. The second is a detour through the pause and exit-2 states partway through a data shift. The bench drives the sequence that takes that detour on purpose, then follows it with a long stretch of random TMS and TDI. That stretch reaches transitions no directed scan uses. A behavioural model tracks every edge of that stretch.

// File: rtl/scan_port_pkg.sv
// Package: shared state, path types and instruction codes for the test port.
// Assumes a 4-bit instruction register; codes are fixed by the port behaviour.
package scan_port_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_ID,
        PATH_BOUND
    } dr_path_e;

    localparam logic [IR_W-1:0] CODE_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] CODE_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] CODE_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] CODE_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE   = 4'b0101;

    // Map an instruction onto the data path it selects.
    function automatic dr_path_e decode_path(input logic [IR_W-1:0] code, input bit has_id);
        if (code == CODE_EXTEST || code == CODE_SAMPLE)
            return PATH_BOUND;
        else if (has_id && code == CODE_IDCODE)
            return PATH_ID;
        else
            return PATH_BYPASS;
    endfunction

endpackage

// File: rtl/scan_port_fsm.sv
// Module: sixteen-state test-port sequencer.
// Advances on every rising tck using tms; synchronous active-low reset forces
// the reset state. Assumes tms is stable around the rising edge.
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    // Next-state selection: every state has one successor per tms level.
    always_comb begin
        case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/scan_port_ir.sv
// Module: instruction shift stage and holding register.
// Captures a fixed pattern, shifts LSB first from tdi, and commits on the
// update state. The reset state reloads RESET_CODE. Assumes rising-edge update.
module scan_port_ir
    import scan_port_pkg::*;
#(
    parameter logic [IR_W-1:0] RESET_CODE = CODE_IDCODE
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] instr,
    output logic            ir_so
);

    logic [IR_W-1:0] sr_q;
    logic [IR_W-1:0] instr_q;

    // Shift stage: capture the fixed pattern, then shift right with tdi at the top.
    always_ff @(posedge tck) begin
        if (!rst_n)
            sr_q <= '0;
        else if (state == ST_IR_CAP)
            sr_q <= IR_CAPTURE;
        else if (state == ST_IR_SHIFT)
            sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    // Holding register: default code on reset, shifted code on update.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET)
            instr_q <= RESET_CODE;
        else if (state == ST_IR_UPD)
            instr_q <= sr_q;
    end

    assign instr = instr_q;
    assign ir_so = sr_q[0];

endmodule

// File: rtl/scan_port_dr.sv
// Module: internal data registers, the one-bit bypass stage and the optional
// identification register. Only the register on the selected path captures
// and shifts. Assumes the boundary path is handled outside this module.
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h3B6D_4C2F,
    parameter bit          HAS_ID   = 1'b1
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_e state,
    input  dr_path_e   path,
    output logic       dr_so
);

    logic bypass_q;

    // Bypass stage: captures 0, then passes tdi with one shift of delay.
    always_ff @(posedge tck) begin
        if (!rst_n)
            bypass_q <= 1'b0;
        else if (path == PATH_BYPASS && state == ST_DR_CAP)
            bypass_q <= 1'b0;
        else if (path == PATH_BYPASS && state == ST_DR_SHIFT)
            bypass_q <= tdi;
    end

    generate
        if (HAS_ID) begin : g_id
            logic [ID_W-1:0] id_q;

            // Identity register: captures the constant and shifts it out LSB first.
            always_ff @(posedge tck) begin
                if (!rst_n)
                    id_q <= '0;
                else if (path == PATH_ID && state == ST_DR_CAP)
                    id_q <= ID_VALUE;
                else if (path == PATH_ID && state == ST_DR_SHIFT)
                    id_q <= {tdi, id_q[ID_W-1:1]};
            end

            assign dr_so = (path == PATH_ID) ? id_q[0] : bypass_q;
        end else begin : g_no_id
            assign dr_so = bypass_q;
        end
    endgenerate

endmodule

// File: rtl/scan_port_ctrl.sv
// Module: top of the test access port. Joins the sequencer, the instruction
// register and the internal data registers. Routes the scan path, raises the
// boundary-chain strobes and retimes tdo to the falling tck edge.
// Assumes ID_VALUE has bit 0 set; the external chain takes tdi directly.
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h3B6D_4C2F,
    parameter bit              HAS_ID   = 1'b1
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            bnd_so,
    output logic            tdo,
    output logic            tdo_oe,
    output logic            bnd_capture,
    output logic            bnd_shift,
    output logic            bnd_update,
    output logic            ext_mode,
    output logic [IR_W-1:0] instr
);

    localparam logic [IR_W-1:0] RESET_CODE = HAS_ID ? CODE_IDCODE : CODE_BYPASS;

    tap_state_e state;
    dr_path_e   path;
    logic       ir_so;
    logic       dr_so;
    logic       serial_d;
    logic       shifting;
    logic       in_bound;
    logic       tdo_q;
    logic       oe_q;

    scan_port_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms     (tms),
        .state_q (state)
    );

    scan_port_ir #(
        .RESET_CODE (RESET_CODE)
    ) u_ir (
        .tck   (tck),
        .rst_n (rst_n),
        .tdi   (tdi),
        .state (state),
        .instr (instr),
        .ir_so (ir_so)
    );

    scan_port_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE),
        .HAS_ID   (HAS_ID)
    ) u_dr (
        .tck   (tck),
        .rst_n (rst_n),
        .tdi   (tdi),
        .state (state),
        .path  (path),
        .dr_so (dr_so)
    );

    // Path decode and boundary-chain controls from the loaded instruction.
    always_comb begin
        path        = decode_path(instr, HAS_ID);
        in_bound    = (path == PATH_BOUND);
        bnd_capture = in_bound && (state == ST_DR_CAP);
        bnd_shift   = in_bound && (state == ST_DR_SHIFT);
        bnd_update  = in_bound && (state == ST_DR_UPD);
        ext_mode    = (instr == CODE_EXTEST);
    end

    // Serial source for the output: instruction stage, selected data path, or idle.
    always_comb begin
        shifting = (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
        case (state)
            ST_IR_SHIFT: serial_d = ir_so;
            ST_DR_SHIFT: serial_d = in_bound ? bnd_so : dr_so;
            default:     serial_d = 1'b0;
        endcase
    end

    // Output retiming on the falling edge, with its enable flag.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            tdo_q <= serial_d;
            oe_q  <= shifting;
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/scan_port_chk.sv
// Module: property checker for the test access port, bound to the top.
// Watches the sequencer state, the instruction and the outputs on rising tck.
module scan_port_chk
    import scan_port_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] instr,
    input logic            tdo_oe,
    input logic            bnd_capture,
    input logic            bnd_shift,
    input logic            bnd_update,
    input logic            ext_mode
);

    logic [2:0] hi_cnt;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n)
            hi_cnt <= 3'd0;
        else if (!tms)
            hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5)
            hi_cnt <= hi_cnt + 3'd1;
    end

    assert_five_high_reset_R3: assert property (@(posedge tck) disable iff (!rst_n)
        hi_cnt == 3'd5 |-> state == ST_RESET);

    assert_reset_loads_id_R3: assert property (@(posedge tck) disable iff (!rst_n)
        state == ST_RESET |=> instr == CODE_IDCODE);

    assert_shift_holds_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DR_SHIFT && !tms) |=> state == ST_DR_SHIFT);

    assert_pause_exit_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IR_EXIT2 && !tms) |=> state == ST_IR_SHIFT);

    assert_oe_only_shift_R8: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

    assert_strobe_onehot_R9: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bnd_capture, bnd_shift, bnd_update}));

    assert_strobe_needs_bound_R9: assert property (@(posedge tck) disable iff (!rst_n)
        (bnd_capture || bnd_shift || bnd_update) |-> (instr == CODE_EXTEST || instr == CODE_SAMPLE));

    assert_ext_rise_on_update_R10: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(ext_mode) |-> $past(state) == ST_IR_UPD);

endmodule

bind scan_port_ctrl scan_port_chk u_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .tms         (tms),
    .state       (state),
    .instr       (instr),
    .tdo_oe      (tdo_oe),
    .bnd_capture (bnd_capture),
    .bnd_shift   (bnd_shift),
    .bnd_update  (bnd_update),
    .ext_mode    (ext_mode)
);

// File: tb/sim_scan_port_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural model of the test port compared after every rising and
// falling edge, plus directed scans for the requirement corner cases.
module sim_scan_port_ctrl;

    localparam logic [31:0] ID = 32'h5E1A_90C7;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       bnd_so = 1'b0;
    logic       tdo, tdo_oe, bnd_capture, bnd_shift, bnd_update, ext_mode;
    logic [3:0] instr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 tck = ~tck;

    scan_port_ctrl #(.ID_W(32), .ID_VALUE(ID), .HAS_ID(1'b1)) u0 (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bnd_capture(bnd_capture), .bnd_shift(bnd_shift),
        .bnd_update(bnd_update), .ext_mode(ext_mode), .instr(instr)
    );

    // Model state numbering, independent of the design.
    localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                   S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                   S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;
    int nx0 [16] = '{S_RTI, S_RTI, S_CDR, S_SHDR, S_SHDR, S_PDR, S_PDR, S_SHDR,
                     S_RTI, S_CIR, S_SHIR, S_SHIR, S_PIR, S_PIR, S_SHIR, S_RTI};
    int nx1 [16] = '{S_TLR, S_SDR, S_SIR, S_E1DR, S_E1DR, S_UDR, S_E2DR, S_UDR,
                     S_SDR, S_TLR, S_E1IR, S_E1IR, S_UIR, S_E2IR, S_UIR, S_SDR};

    int         st = S_TLR;
    logic [3:0] m_ir = 4'b0010;
    bit         irq[$];
    bit         drq[$];
    logic       last_tdo;
    int         sh_cnt = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // 0 bypass, 1 identity, 2 boundary (R5 decode).
    function automatic int m_path();
        if (m_ir == 4'b0000 || m_ir == 4'b0001) return 2;
        if (m_ir == 4'b0010) return 1;
        return 0;
    endfunction

    task automatic model_rise(input bit t, input bit d);
        int p = m_path();
        case (st)
            S_TLR: m_ir = 4'b0010;
            S_CDR: begin
                drq.delete();
                if (p == 1) for (int i = 0; i < 32; i++) drq.push_back(ID[i]);
                else if (p == 0) drq.push_back(1'b0);
            end
            S_SHDR: if (p != 2) begin void'(drq.pop_front()); drq.push_back(d); end
            S_CIR: irq = '{1'b1, 1'b0, 1'b1, 1'b0};
            S_SHIR: begin void'(irq.pop_front()); irq.push_back(d); end
            S_UIR: for (int i = 0; i < 4; i++) m_ir[i] = irq[i];
            default: ;
        endcase
        st = t ? nx1[st] : nx0[st];
    endtask

    // One tck cycle: drive, compare after the rising edge, compare after the falling edge.
    task automatic step(input bit t, input bit d);
        bit bsel;
        logic exp_tdo;
        tms = t; tdi = d; bnd_so = 1'($urandom % 2);
        @(posedge tck); #1;
        model_rise(t, d);
        bsel = (m_path() == 2);
        chk(instr == m_ir, "R4 instr", instr, m_ir);
        chk({bnd_capture, bnd_shift, bnd_update} ==
            {bsel && st == S_CDR, bsel && st == S_SHDR, bsel && st == S_UDR},
            "R9 strobes", {bnd_capture, bnd_shift, bnd_update},
            {bsel && st == S_CDR, bsel && st == S_SHDR, bsel && st == S_UDR});
        chk(ext_mode == (m_ir == 4'b0000), "R10 ext_mode", ext_mode, m_ir == 4'b0000);
        if (bnd_shift) sh_cnt++;
        @(negedge tck); #1;
        if (st == S_SHIR) exp_tdo = irq[0];
        else if (st == S_SHDR) exp_tdo = bsel ? bnd_so : drq[0];
        else exp_tdo = 1'b0;
        chk(tdo_oe == (st == S_SHIR || st == S_SHDR), "R8 oe", tdo_oe, st == S_SHIR || st == S_SHDR);
        chk(tdo == exp_tdo, "R2/R8 tdo", tdo, exp_tdo);
        last_tdo = tdo;
    endtask

    // Data scan of n bits from idle, back to idle.
    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        dout[0] = last_tdo;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            if (i < n - 1) dout[i+1] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    // Instruction scan from idle, back to idle; returns the captured bits.
    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        cap = '0;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        cap[0] = last_tdo;
        for (int i = 0; i < 4; i++) begin
            step(i == 3, code[i]);
            if (i < 3) cap[i+1] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] dout;
        logic [3:0]  cap;
        repeat (3) @(negedge tck);
        #1;
        chk(instr == 4'b0010, "R1 reset instr", instr, 4'b0010);
        chk(tdo_oe == 1'b0, "R1 reset oe", tdo_oe, 0);
        chk(tdo == 1'b0, "R1 reset tdo", tdo, 0);
        rst_n = 1'b1;
        st = S_TLR; m_ir = 4'b0010;
        step(0, 0);

        // R7: identity read straight after reset.
        scan_dr(32, 32'h0, dout);
        chk(dout == ID, "R7 id scan", dout, ID);

        // R4: capture pattern and load of the bypass code.
        scan_ir(4'b1111, cap);
        chk(cap == 4'b0101, "R4 capture", cap, 4'b0101);
        chk(instr == 4'b1111, "R4 loaded", instr, 4'b1111);

        // R6: one-bit delay with a captured zero.
        scan_dr(8, 32'hA5, dout);
        chk(dout[7:0] == {8'hA5 << 1}, "R6 bypass", dout[7:0], 8'h4A);

        // R5: an unlisted code behaves as bypass.
        scan_ir(4'b0110, cap);
        scan_dr(4, 32'hB, dout);
        chk(dout[3:0] == 4'b0110, "R5 unlisted", dout[3:0], 4'b0110);

        // R5/R9: sample/preload routes through the chain without test mode.
        scan_ir(4'b0001, cap);
        chk(ext_mode == 1'b0, "R5 sample no ext", ext_mode, 0);
        sh_cnt = 0;
        scan_dr(6, 32'h2D, dout);
        chk(sh_cnt == 6, "R9 shift count", sh_cnt, 6);

        // R10: external test raises the mode flag.
        scan_ir(4'b0000, cap);
        chk(ext_mode == 1'b1, "R10 extest", ext_mode, 1);
        scan_dr(6, 32'h13, dout);

        // R2: data scan that detours through pause and exit-2.
        scan_ir(4'b1111, cap);
        step(1, 0); step(0, 0); step(0, 1); step(1, 1); step(0, 0); step(0, 0);
        step(1, 0); step(0, 1); step(1, 0); step(1, 0); step(0, 0);

        // R3: five high edges from inside Shift-DR.
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(1, 0);
        chk(instr == 4'b0010, "R3 from shift-dr", instr, 4'b0010);

        // R3: five high edges from inside Shift-IR after loading external test.
        step(0, 0);
        scan_ir(4'b0000, cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 1);
        repeat (5) step(1, 0);
        step(1, 0);
        chk(instr == 4'b0010, "R3 from shift-ir", instr, 4'b0010);
        chk(ext_mode == 1'b0, "R3 ext cleared", ext_mode, 0);

        // R2: random walk compared against the model on every edge.
        for (int k = 0; k < 600; k++)
            step(($urandom % 3) == 0, 1'($urandom % 2));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule